// File: doc/BRIEF.md
# Transmit Mode Arbiter for a 16-bit Source Link

The block decides, once per cycle of the user-side divided clock, what the transmit side of a 16-bit source link drives. There are three kinds of output. The first is payload words taken from the payload FIFO. The second is idle control words. The third is training patterns, which are control words and data words in a fixed sequence. The user supplies an idle request and a training request. The status path supplies an in-frame flag, which a test override can force true. The payload path flags the last word of each burst.

Arbitration takes place only at a switch point. For payload, a switch point is the final word of a burst. Each idle word is a switch point of its own. For training, the switch point is the final word of the whole sequence. The priority is training first, then idle, then payload. If the link is out of frame and the override is clear, idle words are sent in place of payload. The block tells the payload path when to pop a word, so the FIFO is left untouched while idle or training words are sent. It also drives the control-line level for each word, and the driver enable that follows a tristate input.

Top module: `tx_mode_arb`

## Requirements
- R1: While reset is held, `mode_o` is 1 (idle word), `ctl_o` is 1, `pop_o` is 0 and `drv_en_o` is 1.
- R2: While `mode_o` is 0 (payload), the mode is kept whenever `burst_end_i` is low in that cycle, whatever the requests or the frame status. A new mode appears only in the cycle after a cycle in which `mode_o` was 0 and `burst_end_i` was high.
- R3: At a switch point with `train_req_i` high, the next cycle starts a training sequence. This holds whether the idle request is high or low and whatever the frame status.
- R4: At a switch point with `idle_req_i` high and `train_req_i` low, the next cycle shows `mode_o` = 1.
- R5: At a switch point with no request, `in_frame_i` low and `oof_override_i` low, the next cycle shows `mode_o` = 1.
- R6: At a switch point with no request and `oof_override_i` high, the next cycle shows `mode_o` = 0, whatever the value of `in_frame_i`.
- R7: A training sequence is made of one group per repetition, with `train_reps_i` groups in all (a value of 0 counts as 1). Each group is one idle word (`mode_o` = 1), then TRAIN_LEN training control words (`mode_o` = 2), then TRAIN_LEN training data words (`mode_o` = 3). Once the sequence has started, inputs have no effect on it. The cycle after its last word is arbitrated anew.
- R8: `ctl_o` is 1 when `mode_o` is 1 or 2 and 0 when `mode_o` is 0 or 3. `pop_o` is 1 only when `mode_o` is 0.
- R9: `drv_en_o` equals the inverse of the `tristate_i` value sampled at the previous clock edge.
- R10: Outside training, every idle word is a switch point. With the idle request held high, idle words keep coming. In the cycle after the request drops, with the link in frame, `mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User-side divided clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Level request for idle words |
| train_req_i | input | 1 | Level request for training sequences |
| in_frame_i | input | 1 | Status channel is in frame |
| oof_override_i | input | 1 | Treat the status channel as in frame |
| burst_end_i | input | 1 | Current payload word ends its burst |
| tristate_i | input | 1 | High to turn off the clock, data and control drivers |
| train_reps_i | input | REP_W | Number of training groups per sequence (0 counts as 1) |
| mode_o | output | 2 | 0 payload, 1 idle word, 2 training control, 3 training data |
| ctl_o | output | 1 | Control-line level for the current word |
| pop_o | output | 1 | Pop one word from the payload FIFO |
| drv_en_o | output | 1 | Output enable for the link drivers |

## Verification
Suppose the burst position or the training counters hold a wrong value. Then `mode_o` changes mid-burst, or a training run of control or data words comes out one word too long or too short. That error shows at the ports within one group of training words. A wrong priority decision shows in the single cycle after the switch point. A pop enable that leaks into idle or training cycles shows directly as `pop_o` high while `mode_o` is not 0. Sequences with one, two and zero repetitions are checked against counts worked out by hand.

// File: rtl/tx_mode_pkg.sv
package tx_mode_pkg;
  typedef enum logic [1:0] {
    MODE_DATA    = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_TRN_CTL = 2'd2,
    MODE_TRN_DAT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,
    PH_CTL  = 2'd1,
    PH_DAT  = 2'd2
  } phase_e;
endpackage

// File: rtl/tx_mode_prio.sv
module tx_mode_prio (
  input  logic train_req_i,
  input  logic idle_req_i,
  input  logic in_frame_i,
  input  logic oof_override_i,
  output logic sel_train_o,
  output logic sel_idle_o
);
  logic framed;

  assign framed      = in_frame_i | oof_override_i;
  assign sel_train_o = train_req_i;
  // out of frame falls back to idle words
  assign sel_idle_o  = ~train_req_i & (idle_req_i | ~framed);
endmodule

// File: rtl/tx_train_seq.sv
module tx_train_seq
  import tx_mode_pkg::*;
#(
  parameter int TRAIN_LEN = 10,
  parameter int REP_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REP_W-1:0] reps_i,
  output logic             busy_o,
  output logic             last_o,
  output mode_e            mode_o
);
  localparam int CNT_W = (TRAIN_LEN > 1) ? $clog2(TRAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRAIN_LEN - 1);

  logic             busy_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REP_W-1:0] rep_q, reps_q, reps_eff;
  logic             word_last, group_last;

  assign reps_eff   = (reps_i == '0) ? REP_W'(1) : reps_i;
  assign word_last  = (cnt_q == CNT_LAST);
  assign group_last = (rep_q == reps_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= PH_LEAD;
      cnt_q   <= '0;
      rep_q   <= '0;
      reps_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= PH_LEAD;
      cnt_q   <= '0;
      rep_q   <= REP_W'(1);
      reps_q  <= reps_eff;
    end else if (busy_q) begin
      unique case (phase_q)
        PH_LEAD: begin
          phase_q <= PH_CTL;
          cnt_q   <= '0;
        end
        PH_CTL: begin
          if (word_last) begin
            phase_q <= PH_DAT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DAT: begin
          if (word_last) begin
            cnt_q <= '0;
            if (group_last) begin
              busy_q <= 1'b0;
            end else begin
              rep_q   <= rep_q + 1'b1;
              phase_q <= PH_LEAD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_LEAD;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q & (phase_q == PH_DAT) & word_last & group_last;

  always_comb begin
    unique case (phase_q)
      PH_CTL:  mode_o = MODE_TRN_CTL;
      PH_DAT:  mode_o = MODE_TRN_DAT;
      default: mode_o = MODE_IDLE;
    endcase
  end
endmodule

// File: rtl/tx_drv_ctl.sv
module tx_drv_ctl #(
  parameter bit OE_REG = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tristate_i,
  output logic drv_en_o
);
  if (OE_REG) begin : g_reg
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b1;
      else         en_q <= ~tristate_i;
    end
    assign drv_en_o = en_q;
  end else begin : g_comb
    assign drv_en_o = ~tristate_i;
  end
endmodule

// File: rtl/tx_mode_arb.sv
module tx_mode_arb
  import tx_mode_pkg::*;
#(
  parameter int TRAIN_LEN = 10,
  parameter int REP_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_req_i,
  input  logic             train_req_i,
  input  logic             in_frame_i,
  input  logic             oof_override_i,
  input  logic             burst_end_i,
  input  logic             tristate_i,
  input  logic [REP_W-1:0] train_reps_i,
  output logic [1:0]       mode_o,
  output logic             ctl_o,
  output logic             pop_o,
  output logic             drv_en_o
);
  mode_e base_q, seq_mode, cur_mode;
  logic  sel_train, sel_idle;
  logic  seq_busy, seq_last, at_switch, seq_start;

  tx_mode_prio u_prio (
    .train_req_i   (train_req_i),
    .idle_req_i    (idle_req_i),
    .in_frame_i    (in_frame_i),
    .oof_override_i(oof_override_i),
    .sel_train_o   (sel_train),
    .sel_idle_o    (sel_idle)
  );

  tx_train_seq #(
    .TRAIN_LEN(TRAIN_LEN),
    .REP_W    (REP_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(seq_start),
    .reps_i (train_reps_i),
    .busy_o (seq_busy),
    .last_o (seq_last),
    .mode_o (seq_mode)
  );

  tx_drv_ctl #(.OE_REG(1'b1)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tristate_i(tristate_i),
    .drv_en_o  (drv_en_o)
  );

  // idle words are single-word switch points; payload waits for burst end
  always_comb begin
    if (seq_busy)                   at_switch = seq_last;
    else if (base_q == MODE_DATA)   at_switch = burst_end_i;
    else                            at_switch = 1'b1;
  end

  assign seq_start = at_switch & sel_train;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= MODE_IDLE;
    end else if (at_switch) begin
      if (sel_train)     base_q <= MODE_IDLE;
      else if (sel_idle) base_q <= MODE_IDLE;
      else               base_q <= MODE_DATA;
    end
  end

  assign cur_mode = seq_busy ? seq_mode : base_q;
  assign mode_o   = cur_mode;
  assign ctl_o    = (cur_mode == MODE_IDLE) | (cur_mode == MODE_TRN_CTL);
  assign pop_o    = (cur_mode == MODE_DATA);
endmodule

// File: rtl/tx_mode_arb_chk.sv
module tx_mode_arb_chk
  import tx_mode_pkg::*;
#(
  parameter int TRAIN_LEN = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       idle_req_i,
  input logic       train_req_i,
  input logic       in_frame_i,
  input logic       oof_override_i,
  input logic       burst_end_i,
  input logic       tristate_i,
  input logic [1:0] mode_o,
  input logic       drv_en_o,
  input logic       seq_busy
);
  localparam int RUN_W = $clog2(TRAIN_LEN + 1);

  logic [RUN_W-1:0] ctl_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ctl_run <= '0;
    else if (mode_o == MODE_TRN_CTL) ctl_run <= ctl_run + 1'b1;
    else                            ctl_run <= '0;
  end

  assert_burst_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_DATA && !burst_end_i) |=> (mode_o == MODE_DATA));

  assert_train_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_DATA && burst_end_i && train_req_i)
      |=> (mode_o == MODE_IDLE) ##1 (mode_o == MODE_TRN_CTL));

  assert_idle_over_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_DATA && burst_end_i && !train_req_i && idle_req_i)
      |=> (mode_o == MODE_IDLE));

  assert_oof_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_IDLE && !seq_busy && !train_req_i && !in_frame_i && !oof_override_i)
      |=> (mode_o == MODE_IDLE));

  assert_override_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_DATA && burst_end_i && !train_req_i && !idle_req_i && oof_override_i)
      |=> (mode_o == MODE_DATA));

  assert_ctl_run_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_TRN_CTL) |-> (ctl_run < RUN_W'(TRAIN_LEN)));

  assert_ctl_run_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_TRN_CTL && ctl_run == RUN_W'(TRAIN_LEN - 1)) |=> (mode_o == MODE_TRN_DAT));

  assert_drv_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (drv_en_o == !$past(tristate_i)));

  assert_idle_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_IDLE && !seq_busy && !train_req_i && !idle_req_i && in_frame_i)
      |=> (mode_o == MODE_DATA));
endmodule

bind tx_mode_arb tx_mode_arb_chk #(.TRAIN_LEN(TRAIN_LEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .idle_req_i    (idle_req_i),
  .train_req_i   (train_req_i),
  .in_frame_i    (in_frame_i),
  .oof_override_i(oof_override_i),
  .burst_end_i   (burst_end_i),
  .tristate_i    (tristate_i),
  .mode_o        (mode_o),
  .drv_en_o      (drv_en_o),
  .seq_busy      (seq_busy)
);

// File: tb/tx_mode_arb_bench.sv
`timescale 1ns/1ps
module tx_mode_arb_bench;
  localparam int TRAIN_LEN = 10;
  localparam int REP_W     = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             idle_req, train_req, in_frame, oof_ovr, burst_end, tristate;
  logic [REP_W-1:0] reps;
  logic [1:0]       mode;
  logic             ctl, pop, drv_en;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [1:0] q_mode[$];
  logic       q_drv[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  tx_mode_arb #(.TRAIN_LEN(TRAIN_LEN), .REP_W(REP_W)) u_tx_mode_arb (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .idle_req_i    (idle_req),
    .train_req_i   (train_req),
    .in_frame_i    (in_frame),
    .oof_override_i(oof_ovr),
    .burst_end_i   (burst_end),
    .tristate_i    (tristate),
    .train_reps_i  (reps),
    .mode_o        (mode),
    .ctl_o         (ctl),
    .pop_o         (pop),
    .drv_en_o      (drv_en)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R8: control line high for modes 1,2; pop only in mode 0
  function automatic logic exp_ctl(logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  // monitor: one expected entry per clock edge after the driver pushed it
  always @(posedge clk) begin
    #1;
    if (q_mode.size() > 0) begin
      logic [1:0] em;
      logic       ed;
      string      et;
      em = q_mode.pop_front();
      ed = q_drv.pop_front();
      et = q_tag.pop_front();
      check({et, " mode"}, mode, em);
      check("R8 ctl", ctl, exp_ctl(em));
      check("R8 pop", pop, (em == 2'd0));
      check("R9 drv_en", drv_en, ed);
    end
  end

  // driver: inputs at the falling edge, expected output after the next rising edge
  task automatic step(bit tr, bit id, bit fr, bit ov, bit be, bit ts,
                      int r, logic [1:0] em, string tag);
    @(negedge clk);
    train_req = tr; idle_req = id; in_frame = fr; oof_ovr = ov;
    burst_end = be; tristate = ts; reps = REP_W'(r);
    q_mode.push_back(em);
    q_drv.push_back(!ts);
    q_tag.push_back(tag);
  endtask

  task automatic train_body(bit tr, bit fr, bit ts, int r);
    for (int i = 0; i < TRAIN_LEN; i++) step(tr, 1'b0, fr, 1'b0, 1'b1, ts, r, 2'd2, "R7 ctl");
    for (int i = 0; i < TRAIN_LEN; i++) step(tr, 1'b0, fr, 1'b0, 1'b0, ts, r, 2'd3, "R7 dat");
  endtask

  initial begin
    idle_req = 0; train_req = 0; in_frame = 0; oof_ovr = 0;
    burst_end = 0; tristate = 0; reps = '0;
    #7;
    check("R1 mode", mode, 1);
    check("R1 ctl", ctl, 1);
    check("R1 pop", pop, 0);
    check("R1 drv_en", drv_en, 1);
    @(negedge clk);
    rst_ni = 1'b1;

    // payload start, mid-burst requests ignored (R2, R10)
    step(0,0,1,0,0,0,1, 2'd0, "R10 start");
    step(0,1,1,0,0,0,1, 2'd0, "R2 idle mid");
    step(1,0,1,0,0,0,1, 2'd0, "R2 train mid");
    step(0,0,1,0,0,1,1, 2'd0, "R2 tristate");
    // idle at burst end, held, then released
    step(0,1,1,0,1,0,1, 2'd1, "R4");
    step(0,1,1,0,0,0,1, 2'd1, "R10 hold");
    step(0,1,1,0,0,1,1, 2'd1, "R10 hold");
    step(0,0,1,0,0,0,1, 2'd0, "R10 release");
    // training beats idle at burst end, one group
    step(1,1,1,0,1,0,1, 2'd1, "R3 lead");
    train_body(0, 1, 0, 1);
    step(0,1,1,0,0,0,1, 2'd1, "R4 after train");
    // two groups, request held throughout
    step(1,0,1,0,0,0,2, 2'd1, "R3 from idle");
    train_body(1, 1, 1, 2);
    step(1,0,1,0,0,0,2, 2'd1, "R7 second lead");
    train_body(1, 0, 0, 2);
    step(0,0,0,0,0,0,2, 2'd1, "R5 oof");
    step(0,0,0,0,1,1,2, 2'd1, "R5 oof hold");
    step(0,0,0,1,0,0,2, 2'd0, "R6 override");
    step(0,0,0,1,0,0,2, 2'd0, "R6 override");
    step(0,0,0,1,1,0,2, 2'd0, "R6 at burst end");
    step(0,0,0,0,0,0,2, 2'd0, "R2 oof mid");
    step(0,0,0,0,1,0,2, 2'd1, "R5 at burst end");
    // zero repetitions behaves as one group
    step(0,0,1,0,0,0,0, 2'd0, "R10 back");
    step(1,0,1,0,1,0,0, 2'd1, "R3 reps0 lead");
    train_body(0, 1, 0, 0);
    step(0,0,1,0,0,0,0, 2'd0, "R7 reps0 end");
    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule